// File: doc/BRIEF.md
# Keypad Controller Command Decoder

This block turns the byte stream delivered by a serial slave front end into register accesses for a keypad and GPIO controller. A bus start condition restarts a byte counter. In a write transaction the first byte picks a command code, and each later byte is an argument, numbered from zero. In a read transaction each byte strobe returns one byte of the register picked by the last command code. The byte counter indexes that byte.

The block holds the configuration, active-time, debounce, keypad-size and clock settings, the three 16-bit GPIO words (pull, direction, output state), the error register and the interrupt status. Every argument is range-checked and flagged in the error register. When a command has taken all of its arguments, the selected code is parked on 0xFF, so a surplus argument byte counts as a bad parameter.

Codes owned by the key FIFO and the PWM engines are not decoded here. Their arguments leave on the argument ports, and their read bytes come in from `ext_rd_data_i`.

Top module: `kpd_cmd_decoder`

## Requirements
- R1: After hard reset the outputs are: configuration 0x80, active time 125, debounce 3, keypad size 0x33, clock 0x08, status 0x10 (bit 4 = not initialised), error 0x00, all GPIO words 0x0000, selected code 0xFF, byte index 0, and `irq_n_o` low.
- R2: A bus start sets `byte_idx_o` to 0. In a write, the byte taken at index 0 becomes `cmd_o`. Any later byte raises `arg_stb_o` in the same cycle, with `arg_o` equal to the byte, and the argument number is `byte_idx_o`-1. The index saturates at its maximum.
- R3: Code 0x83 with argument 0xAA restores the R1 values of configuration, active time, debounce, size, clock and status (0x10). It leaves error and GPIO words unchanged. Any other argument sets error bit 0 and changes no setting.
- R4: Codes 0x84 (pull), 0x85 (direction) and 0x86 (state) take two arguments. Argument 0 loads the byte into bits 7:0 and clears bits 15:8. Argument 1 is ORed into bits 15:8.
- R5: Code 0x90 always stores its argument as keypad size. It sets error bit 0 when bits 3:0 are outside 3..12 or bits 7:4 are outside 3..8.
- R6: Code 0x8F stores the debounce value and sets error bit 0 when the value is zero. Code 0x8B stores the active time without a check.
- R7: Code 0x93 always stores the clock byte. It sets error bit 0 when bits 1:0 are 01 or 10.
- R8: After the single argument of 0x81, 0x83, 0x8B, 0x8F, 0x90 or 0x93, or after argument 1 of 0x84..0x86, the selected code becomes 0xFF. An argument taken while 0xFF is selected sets error bit 0 and stores nothing.
- R9: A code that is neither decoded here nor delegated (R13) sets error bit 1 on each argument byte written under it and on each byte read under it. Such a read returns 0x00.
- R10: Read data appears on `rd_data_o` one cycle after the strobe. Code 0x80 returns 0x00, 0x04, then 0x00. Codes 0x87 and 0x88 return direction and state low byte, high byte, then 0x00. Code 0x82 returns status at index 0 and 0x00 after. Codes 0x8C (error), 0x91 (size), 0x92 (configuration bits 3:0, upper bits zero) and 0x94 (clock with bits 1:0 forced to 10) return the same byte at every index.
- R11: Any error bit that is set also sets status bit 3. Error bits stay set until hard reset. `irq_n_o` is low exactly when status is nonzero.
- R12: A status read clears status after the byte when status bit 4 is clear. Otherwise status is kept. Code 0x81 stores its argument as configuration and clears all of status.
- R13: Delegated codes 0x89, 0x8A, 0x8E, 0x95, 0x96 and 0x97 raise no error and are not parked on 0xFF. A read under them raises `ext_rd_o` in the strobe cycle and returns `ext_rd_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| bus_start_i | input | 1 | Bus start condition; restarts the byte count |
| wr_stb_i | input | 1 | A written byte is present |
| wr_byte_i | input | 8 | Written byte |
| rd_stb_i | input | 1 | A read byte is requested |
| ext_rd_data_i | input | 8 | Read byte supplied for delegated codes |
| rd_data_o | output | 8 | Read byte, valid one cycle after the strobe |
| ext_rd_o | output | 1 | Read strobe under a delegated code |
| cmd_o | output | 8 | Selected command code |
| byte_idx_o | output | 4 | Byte count since the last start |
| arg_stb_o | output | 1 | Argument byte strobe |
| arg_o | output | 8 | Argument byte |
| cfg_o | output | 8 | Configuration |
| active_o | output | 8 | Active time |
| debounce_o | output | 8 | Debounce time |
| size_o | output | 8 | Keypad size |
| clock_o | output | 8 | Clock setting |
| pull_o | output | 16 | GPIO pull word |
| dir_o | output | 16 | GPIO direction word |
| state_o | output | 16 | GPIO output state word |
| err_o | output | 8 | Error flags (bit 0 bad parameter, bit 1 unknown code) |
| status_o | output | 8 | Interrupt status (bit 3 error, bit 4 not initialised) |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults: 8-bit bytes, 16-bit GPIO words, a 4-bit byte counter and keypad limits of 3..12 rows by 3..8 columns. These values place the size-check edges (nibbles 2, 3, 8, 9, 12, 13) and the third byte of every two-byte register, where the 0x00 fill starts, within short transactions. The random argument mix is weighted towards the soft-reset key, zero, near-limit sizes and each clock-bit pattern. This drives the parked 0xFF code, the sticky errors and the status clearing rules together.

// File: rtl/kpd_cmd_pkg.sv
package kpd_cmd_pkg;
   // command codes; the numbering is fixed by the host protocol
   localparam logic [7:0] C_ID_R    = 8'h80;
   localparam logic [7:0] C_CFG_W   = 8'h81;
   localparam logic [7:0] C_STAT_R  = 8'h82;
   localparam logic [7:0] C_SRST    = 8'h83;
   localparam logic [7:0] C_PULL_W  = 8'h84;
   localparam logic [7:0] C_DIR_W   = 8'h85;
   localparam logic [7:0] C_STATE_W = 8'h86;
   localparam logic [7:0] C_DIR_R   = 8'h87;
   localparam logic [7:0] C_STATE_R = 8'h88;
   localparam logic [7:0] C_ACT_W   = 8'h8B;
   localparam logic [7:0] C_ERR_R   = 8'h8C;
   localparam logic [7:0] C_DBN_W   = 8'h8F;
   localparam logic [7:0] C_SIZE_W  = 8'h90;
   localparam logic [7:0] C_SIZE_R  = 8'h91;
   localparam logic [7:0] C_CFG_R   = 8'h92;
   localparam logic [7:0] C_CLK_W   = 8'h93;
   localparam logic [7:0] C_CLK_R   = 8'h94;
   localparam logic [7:0] C_PARKED  = 8'hFF;

   localparam int NUM_WORDS = 3;
   localparam logic [7:0] WORD_CODES [NUM_WORDS] = '{C_PULL_W, C_DIR_W, C_STATE_W};

   // bit positions
   localparam int ERR_BADARG  = 0;
   localparam int ERR_UNKNOWN = 1;
   localparam int ST_ERROR    = 3;
   localparam int ST_NOINIT   = 4;

   function automatic logic is_delegated(input logic [7:0] c);
      return (c == 8'h89) || (c == 8'h8A) || (c == 8'h8E) ||
             (c == 8'h95) || (c == 8'h96) || (c == 8'h97);
   endfunction
endpackage

// File: rtl/kpd_byte_seq.sv
module kpd_byte_seq #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              wr_stb_i,
   input  logic [BYTE_W-1:0] wr_byte_i,
   input  logic              rd_stb_i,
   input  logic              retire_i,
   output logic [BYTE_W-1:0] cmd_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              arg_stb_o,
   output logic              rd_go_o
);
   import kpd_cmd_pkg::*;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic step;
   assign step      = (wr_stb_i | rd_stb_i) & ~start_i;
   assign arg_stb_o = wr_stb_i & ~start_i & (cnt_o != '0);
   assign rd_go_o   = rd_stb_i & ~start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
         cmd_o <= BYTE_W'(C_PARKED);
      end else if (start_i) begin
         cnt_o <= '0;
      end else if (step) begin
         if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
         if (wr_stb_i) begin
            if (cnt_o == '0)   cmd_o <= wr_byte_i;
            else if (retire_i) cmd_o <= BYTE_W'(C_PARKED);
         end
      end
   end
endmodule

// File: rtl/kpd_arg_check.sv
module kpd_arg_check #(
   parameter int BYTE_W      = 8,
   parameter int CNT_W       = 4,
   parameter int KP_MIN      = 3,
   parameter int KP_ROWS_MAX = 12,
   parameter int KP_COLS_MAX = 8,
   parameter logic [BYTE_W-1:0] SRST_KEY = 8'hAA
) (
   input  logic [BYTE_W-1:0] cmd_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [BYTE_W-1:0] arg_i,
   output logic              bad_o,
   output logic              unk_o,
   output logic              retire_o,
   output logic              srst_o
);
   import kpd_cmd_pkg::*;
   localparam int NIB = BYTE_W / 2;
   localparam logic [CNT_W-1:0] FIRST_ARG = CNT_W'(1);

   logic [NIB-1:0] rows, cols;
   assign rows = arg_i[NIB-1:0];
   assign cols = arg_i[BYTE_W-1:NIB];

   always_comb begin
      bad_o    = 1'b0;
      unk_o    = 1'b0;
      retire_o = 1'b0;
      srst_o   = 1'b0;
      unique case (cmd_i)
         C_CFG_W, C_ACT_W: retire_o = 1'b1;
         C_SRST: begin
            retire_o = 1'b1;
            srst_o   = (arg_i == SRST_KEY);
            bad_o    = (arg_i != SRST_KEY);
         end
         C_PULL_W, C_DIR_W, C_STATE_W: retire_o = (cnt_i != FIRST_ARG);
         C_DBN_W: begin
            retire_o = 1'b1;
            bad_o    = (arg_i == '0);
         end
         C_SIZE_W: begin
            retire_o = 1'b1;
            bad_o    = (int'(rows) < KP_MIN) || (int'(rows) > KP_ROWS_MAX) ||
                       (int'(cols) < KP_MIN) || (int'(cols) > KP_COLS_MAX);
         end
         C_CLK_W: begin
            retire_o = 1'b1;
            bad_o    = arg_i[1] ^ arg_i[0];
         end
         C_PARKED: bad_o = 1'b1;
         default:  unk_o = ~is_delegated(cmd_i);
      endcase
   end
endmodule

// File: rtl/kpd_split_word.sv
module kpd_split_word #(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo_i,
   input  logic              ld_hi_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [WORD_W-1:0] word_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_o <= '0;
      else if (ld_lo_i) word_o <= WORD_W'(byte_i);
      else if (ld_hi_i) word_o[WORD_W-1 -: BYTE_W] <= word_o[WORD_W-1 -: BYTE_W] | byte_i;
   end
endmodule

// File: rtl/kpd_reg_bank.sv
module kpd_reg_bank #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 4,
   parameter int WORD_W = 16,
   parameter logic [BYTE_W-1:0] RST_CFG  = 8'h80,
   parameter logic [BYTE_W-1:0] RST_ACT  = 8'd125,
   parameter logic [BYTE_W-1:0] RST_DBN  = 8'd3,
   parameter logic [BYTE_W-1:0] RST_SIZE = 8'h33,
   parameter logic [BYTE_W-1:0] RST_CLK  = 8'h08,
   parameter logic [WORD_W-1:0] ID_VALUE = 16'h0400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arg_stb_i,
   input  logic [BYTE_W-1:0] cmd_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [BYTE_W-1:0] arg_i,
   input  logic              bad_i,
   input  logic              unk_i,
   input  logic              srst_i,
   input  logic              rd_go_i,
   input  logic [BYTE_W-1:0] ext_rd_data_i,
   output logic [BYTE_W-1:0] rd_data_o,
   output logic              ext_rd_o,
   output logic [BYTE_W-1:0] cfg_o,
   output logic [BYTE_W-1:0] active_o,
   output logic [BYTE_W-1:0] debounce_o,
   output logic [BYTE_W-1:0] size_o,
   output logic [BYTE_W-1:0] clock_o,
   output logic [WORD_W-1:0] pull_o,
   output logic [WORD_W-1:0] dir_o,
   output logic [WORD_W-1:0] state_o,
   output logic [BYTE_W-1:0] err_o,
   output logic [BYTE_W-1:0] status_o,
   output logic              irq_n_o
);
   import kpd_cmd_pkg::*;
   localparam logic [CNT_W-1:0] IDX_LO = CNT_W'(1);
   localparam logic [CNT_W-1:0] IDX_HI = CNT_W'(2);
   localparam logic [BYTE_W-1:0] ST_RESET = BYTE_W'(1) << ST_NOINIT;

   function automatic logic [BYTE_W-1:0] pick(input logic [WORD_W-1:0] w,
                                               input logic [CNT_W-1:0] i);
      logic [WORD_W-1:0] s;
      s = w >> (BYTE_W * int'(i));
      return s[BYTE_W-1:0];
   endfunction

   // ---------------- GPIO words ----------------
   logic [WORD_W-1:0] words [NUM_WORDS];
   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      logic hit;
      assign hit = arg_stb_i && (cmd_i == BYTE_W'(WORD_CODES[g]));
      kpd_split_word #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_word (
         .clk     (clk),
         .rst_n   (rst_n),
         .ld_lo_i (hit && (cnt_i == IDX_LO)),
         .ld_hi_i (hit && (cnt_i == IDX_HI)),
         .byte_i  (arg_i),
         .word_o  (words[g])
      );
   end
   assign pull_o  = words[0];
   assign dir_o   = words[1];
   assign state_o = words[2];

   // ---------------- read path ----------------
   logic [BYTE_W-1:0] rd_val;
   logic              rd_unk, rd_ext;
   always_comb begin
      rd_val = '0;
      rd_unk = 1'b0;
      rd_ext = 1'b0;
      unique case (cmd_i)
         C_ID_R:    rd_val = pick(ID_VALUE, cnt_i);
         C_STAT_R:  rd_val = pick(WORD_W'(status_o), cnt_i);
         C_DIR_R:   rd_val = pick(dir_o, cnt_i);
         C_STATE_R: rd_val = pick(state_o, cnt_i);
         C_ERR_R:   rd_val = err_o;
         C_SIZE_R:  rd_val = size_o;
         C_CFG_R:   rd_val = {{(BYTE_W-4){1'b0}}, cfg_o[3:0]};
         C_CLK_R:   rd_val = {clock_o[BYTE_W-1:2], 2'b10};
         default: begin
            rd_ext = is_delegated(cmd_i);
            rd_unk = ~rd_ext;
            rd_val = rd_ext ? ext_rd_data_i : '0;
         end
      endcase
   end
   assign ext_rd_o = rd_go_i & rd_ext;

   // ---------------- flags ----------------
   logic [BYTE_W-1:0] err_set, status_n;
   logic              cfg_wr;
   assign cfg_wr = arg_stb_i && (cmd_i == C_CFG_W);

   always_comb begin
      err_set              = '0;
      err_set[ERR_BADARG]  = arg_stb_i & bad_i;
      err_set[ERR_UNKNOWN] = (arg_stb_i & unk_i) | (rd_go_i & rd_unk);
      status_n = status_o;
      if (arg_stb_i && srst_i)  status_n = ST_RESET;
      else if (cfg_wr)          status_n = '0;
      else if (rd_go_i && (cmd_i == C_STAT_R) && !status_o[ST_NOINIT])
                                status_n = '0;
      else if (err_set != '0)   status_n[ST_ERROR] = 1'b1;
   end

   assign irq_n_o = (status_o == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_o      <= '0;
         status_o   <= ST_RESET;
         cfg_o      <= RST_CFG;
         active_o   <= RST_ACT;
         debounce_o <= RST_DBN;
         size_o     <= RST_SIZE;
         clock_o    <= RST_CLK;
         rd_data_o  <= '0;
      end else begin
         err_o    <= err_o | err_set;
         status_o <= status_n;
         if (rd_go_i) rd_data_o <= rd_val;
         if (arg_stb_i && srst_i) begin
            cfg_o      <= RST_CFG;
            active_o   <= RST_ACT;
            debounce_o <= RST_DBN;
            size_o     <= RST_SIZE;
            clock_o    <= RST_CLK;
         end else if (arg_stb_i) begin
            if (cmd_i == C_CFG_W)  cfg_o      <= arg_i;
            if (cmd_i == C_ACT_W)  active_o   <= arg_i;
            if (cmd_i == C_DBN_W)  debounce_o <= arg_i;
            if (cmd_i == C_SIZE_W) size_o     <= arg_i;
            if (cmd_i == C_CLK_W)  clock_o    <= arg_i;
         end
      end
   end
endmodule

// File: rtl/kpd_cmd_decoder.sv
module kpd_cmd_decoder #(
   parameter int BYTE_W      = 8,
   parameter int WORD_W      = 16,
   parameter int CNT_W       = 4,
   parameter int KP_MIN      = 3,
   parameter int KP_ROWS_MAX = 12,
   parameter int KP_COLS_MAX = 8,
   parameter logic [7:0]  SRST_KEY = 8'hAA,
   parameter logic [7:0]  RST_CFG  = 8'h80,
   parameter logic [7:0]  RST_ACT  = 8'd125,
   parameter logic [7:0]  RST_DBN  = 8'd3,
   parameter logic [7:0]  RST_SIZE = 8'h33,
   parameter logic [7:0]  RST_CLK  = 8'h08,
   parameter logic [15:0] ID_VALUE = 16'h0400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start_i,
   input  logic              wr_stb_i,
   input  logic [BYTE_W-1:0] wr_byte_i,
   input  logic              rd_stb_i,
   input  logic [BYTE_W-1:0] ext_rd_data_i,
   output logic [BYTE_W-1:0] rd_data_o,
   output logic              ext_rd_o,
   output logic [BYTE_W-1:0] cmd_o,
   output logic [CNT_W-1:0]  byte_idx_o,
   output logic              arg_stb_o,
   output logic [BYTE_W-1:0] arg_o,
   output logic [BYTE_W-1:0] cfg_o,
   output logic [BYTE_W-1:0] active_o,
   output logic [BYTE_W-1:0] debounce_o,
   output logic [BYTE_W-1:0] size_o,
   output logic [BYTE_W-1:0] clock_o,
   output logic [WORD_W-1:0] pull_o,
   output logic [WORD_W-1:0] dir_o,
   output logic [WORD_W-1:0] state_o,
   output logic [BYTE_W-1:0] err_o,
   output logic [BYTE_W-1:0] status_o,
   output logic              irq_n_o
);
   // elaboration-time parameter checks
   if (BYTE_W != 8) begin : g_bad_byte
      $error("kpd_cmd_decoder: command codes need BYTE_W of 8");
   end
   if (WORD_W != 2 * BYTE_W) begin : g_bad_word
      $error("kpd_cmd_decoder: GPIO words are two bytes wide");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("kpd_cmd_decoder: counter must reach index 2");
   end
   if (KP_MIN > KP_COLS_MAX || KP_ROWS_MAX >= (1 << (BYTE_W / 2))) begin : g_bad_kp
      $error("kpd_cmd_decoder: keypad limits do not fit a nibble");
   end

   logic bad, unk, retire, srst, rd_go;

   kpd_byte_seq #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (bus_start_i),
      .wr_stb_i  (wr_stb_i),
      .wr_byte_i (wr_byte_i),
      .rd_stb_i  (rd_stb_i),
      .retire_i  (retire),
      .cmd_o     (cmd_o),
      .cnt_o     (byte_idx_o),
      .arg_stb_o (arg_stb_o),
      .rd_go_o   (rd_go)
   );

   assign arg_o = wr_byte_i;

   kpd_arg_check #(
      .BYTE_W(BYTE_W), .CNT_W(CNT_W), .KP_MIN(KP_MIN),
      .KP_ROWS_MAX(KP_ROWS_MAX), .KP_COLS_MAX(KP_COLS_MAX), .SRST_KEY(SRST_KEY)
   ) u_check (
      .cmd_i    (cmd_o),
      .cnt_i    (byte_idx_o),
      .arg_i    (wr_byte_i),
      .bad_o    (bad),
      .unk_o    (unk),
      .retire_o (retire),
      .srst_o   (srst)
   );

   kpd_reg_bank #(
      .BYTE_W(BYTE_W), .CNT_W(CNT_W), .WORD_W(WORD_W),
      .RST_CFG(RST_CFG), .RST_ACT(RST_ACT), .RST_DBN(RST_DBN),
      .RST_SIZE(RST_SIZE), .RST_CLK(RST_CLK), .ID_VALUE(ID_VALUE)
   ) u_bank (
      .clk           (clk),
      .rst_n         (rst_n),
      .arg_stb_i     (arg_stb_o),
      .cmd_i         (cmd_o),
      .cnt_i         (byte_idx_o),
      .arg_i         (wr_byte_i),
      .bad_i         (bad),
      .unk_i         (unk),
      .srst_i        (srst),
      .rd_go_i       (rd_go),
      .ext_rd_data_i (ext_rd_data_i),
      .rd_data_o     (rd_data_o),
      .ext_rd_o      (ext_rd_o),
      .cfg_o         (cfg_o),
      .active_o      (active_o),
      .debounce_o    (debounce_o),
      .size_o        (size_o),
      .clock_o       (clock_o),
      .pull_o        (pull_o),
      .dir_o         (dir_o),
      .state_o       (state_o),
      .err_o         (err_o),
      .status_o      (status_o),
      .irq_n_o       (irq_n_o)
   );
endmodule

// File: rtl/kpd_cmd_decoder_chk.sv
module kpd_cmd_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_start_i,
   input logic       rd_stb_i,
   input logic [7:0] rd_data_o,
   input logic [7:0] cmd_o,
   input logic [3:0] byte_idx_o,
   input logic       arg_stb_o,
   input logic [7:0] arg_o,
   input logic [7:0] err_o,
   input logic [7:0] status_o
);
   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((err_o & $past(err_o)) == $past(err_o)));

   // R11
   err_flags_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err_o) |-> status_o[3]);

   // R2
   start_clears_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start_i |=> (byte_idx_o == 4'd0));

   // R8
   single_arg_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arg_stb_o && (cmd_o == 8'h81 || cmd_o == 8'h83 || cmd_o == 8'h8B ||
                     cmd_o == 8'h8F || cmd_o == 8'h90 || cmd_o == 8'h93))
      |=> (cmd_o == 8'hFF));

   // R6
   zero_debounce_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arg_stb_o && cmd_o == 8'h8F && arg_o == 8'h00) |=> err_o[0]);

   // R10
   clock_read_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && !bus_start_i && cmd_o == 8'h94) |=> (rd_data_o[1:0] == 2'b10));

   // R9
   parked_read_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && !bus_start_i && cmd_o == 8'hFF) |=> (err_o[1] && rd_data_o == 8'h00));
endmodule

bind kpd_cmd_decoder kpd_cmd_decoder_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_start_i (bus_start_i),
   .rd_stb_i    (rd_stb_i),
   .rd_data_o   (rd_data_o),
   .cmd_o       (cmd_o),
   .byte_idx_o  (byte_idx_o),
   .arg_stb_o   (arg_stb_o),
   .arg_o       (arg_o),
   .err_o       (err_o),
   .status_o    (status_o)
);

// File: tb/kpd_cmd_decoder_bench.sv
module kpd_cmd_decoder_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_start_i = 1'b0, wr_stb_i = 1'b0, rd_stb_i = 1'b0;
   logic [7:0] wr_byte_i = '0, ext_rd_data_i = 8'h5A;
   logic [7:0] rd_data_o, cmd_o, arg_o, cfg_o, active_o, debounce_o, size_o, clock_o, err_o, status_o;
   logic [3:0] byte_idx_o;
   logic ext_rd_o, arg_stb_o, irq_n_o;
   logic [15:0] pull_o, dir_o, state_o;

   always #2 clk = ~clk;

   kpd_cmd_decoder u_kpd_cmd_decoder (.*);

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // reference state
   logic [7:0] m_cfg, m_act, m_dbn, m_size, m_clk, m_err, m_st, m_cmd;
   logic [15:0] m_pull, m_dir, m_state;
   int m_cnt;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit deleg(input logic [7:0] c);
      return c == 8'h89 || c == 8'h8A || c == 8'h8E || c == 8'h95 || c == 8'h96 || c == 8'h97;
   endfunction

   task automatic m_reset_settings();
      m_cfg = 8'h80; m_act = 8'd125; m_dbn = 8'd3; m_size = 8'h33; m_clk = 8'h08; m_st = 8'h10;
   endtask

   task automatic m_flag(input int bitn);
      m_err[bitn] = 1'b1;
      m_st[3] = 1'b1;
   endtask

   task automatic m_write(input logic [7:0] b);
      if (m_cnt == 0) m_cmd = b;
      else begin
         case (m_cmd)
            8'h81: begin m_cfg = b; m_st = 0; m_cmd = 8'hFF; end
            8'h83: begin if (b == 8'hAA) m_reset_settings(); else m_flag(0); m_cmd = 8'hFF; end
            8'h84, 8'h85, 8'h86: begin
               logic [15:0] w;
               w = (m_cmd == 8'h84) ? m_pull : (m_cmd == 8'h85) ? m_dir : m_state;
               if (m_cnt == 1) w = {8'h00, b};
               else begin w[15:8] = w[15:8] | b; m_cmd = 8'hFF; end
               if (m_cnt != 1) ;
               case (w === w)
                  default: ;
               endcase
               if (u_sel(8'h84)) m_pull = w;
               if (u_sel(8'h85)) m_dir = w;
               if (u_sel(8'h86)) m_state = w;
            end
            8'h8B: begin m_act = b; m_cmd = 8'hFF; end
            8'h8F: begin m_dbn = b; if (b == 0) m_flag(0); m_cmd = 8'hFF; end
            8'h90: begin
               m_size = b;
               if (b[3:0] < 3 || b[3:0] > 12 || b[7:4] < 3 || b[7:4] > 8) m_flag(0);
               m_cmd = 8'hFF;
            end
            8'h93: begin m_clk = b; if (b[1:0] == 2'b01 || b[1:0] == 2'b10) m_flag(0); m_cmd = 8'hFF; end
            8'hFF: m_flag(0);
            default: if (!deleg(m_cmd)) m_flag(1);
         endcase
      end
      if (m_cnt < 15) m_cnt++;
   endtask

   // which word the pending GPIO write targets (m_cmd may already be parked)
   logic [7:0] gpio_tgt;
   function automatic bit u_sel(input logic [7:0] c);
      return gpio_tgt == c;
   endfunction

   function automatic logic [7:0] byte_of(input logic [15:0] w, input int i);
      return (i == 0) ? w[7:0] : (i == 1) ? w[15:8] : 8'h00;
   endfunction

   task automatic m_read(output logic [7:0] v, output string tag);
      tag = "R10";
      case (m_cmd)
         8'h80: v = byte_of(16'h0400, m_cnt);
         8'h82: begin v = (m_cnt == 0) ? m_st : 8'h00; tag = "R12"; if (!m_st[4]) m_st = 0; end
         8'h87: v = byte_of(m_dir, m_cnt);
         8'h88: v = byte_of(m_state, m_cnt);
         8'h8C: v = m_err;
         8'h91: v = m_size;
         8'h92: v = {4'h0, m_cfg[3:0]};
         8'h94: v = {m_clk[7:2], 2'b10};
         default: if (deleg(m_cmd)) begin v = ext_rd_data_i; tag = "R13"; end
                  else begin v = 8'h00; tag = "R9"; m_flag(1); end
      endcase
      if (m_cnt < 15) m_cnt++;
   endtask

   task automatic check_all();
      chk("R3 cfg", {8'h0, cfg_o}, {8'h0, m_cfg});
      chk("R6 active", {8'h0, active_o}, {8'h0, m_act});
      chk("R6 debounce", {8'h0, debounce_o}, {8'h0, m_dbn});
      chk("R5 size", {8'h0, size_o}, {8'h0, m_size});
      chk("R7 clock", {8'h0, clock_o}, {8'h0, m_clk});
      chk("R4 pull", pull_o, m_pull);
      chk("R4 dir", dir_o, m_dir);
      chk("R4 state", state_o, m_state);
      chk("R9 err", {8'h0, err_o}, {8'h0, m_err});
      chk("R11 status", {8'h0, status_o}, {8'h0, m_st});
      chk("R11 irq", {15'h0, irq_n_o}, {15'h0, m_st == 0});
      chk("R8 cmd", {8'h0, cmd_o}, {8'h0, m_cmd});
      chk("R2 idx", {12'h0, byte_idx_o}, 16'(m_cnt));
   endtask

   task automatic bstart();
      @(negedge clk); bus_start_i = 1'b1;
      @(negedge clk); bus_start_i = 1'b0;
      m_cnt = 0;
      chk("R2 start", {12'h0, byte_idx_o}, 16'h0);
   endtask

   task automatic send(input logic [7:0] b);
      bit exp_stb;
      exp_stb = (m_cnt != 0);
      gpio_tgt = m_cmd;
      @(negedge clk); wr_stb_i = 1'b1; wr_byte_i = b;
      #1;
      chk("R2 arg_stb", {15'h0, arg_stb_o}, {15'h0, exp_stb});
      if (exp_stb) chk("R2 arg", {8'h0, arg_o}, {8'h0, b});
      m_write(b);
      @(negedge clk); wr_stb_i = 1'b0;
      check_all();
   endtask

   task automatic rdb();
      logic [7:0] exp;
      string tag;
      bit exp_ext;
      exp_ext = deleg(m_cmd);
      m_read(exp, tag);
      @(negedge clk); rd_stb_i = 1'b1;
      #1;
      chk("R13 ext_rd", {15'h0, ext_rd_o}, {15'h0, exp_ext});
      @(negedge clk); rd_stb_i = 1'b0;
      chk(tag, {8'h0, rd_data_o}, {8'h0, exp});
      check_all();
   endtask

   task automatic wtx(input logic [7:0] c, input int n, input logic [7:0] a0 = 0,
                      input logic [7:0] a1 = 0, input logic [7:0] a2 = 0);
      bstart();
      send(c);
      if (n > 0) send(a0);
      if (n > 1) send(a1);
      if (n > 2) send(a2);
   endtask

   task automatic rtx(input logic [7:0] c, input int n);
      bstart();
      send(c);
      bstart();
      for (int i = 0; i < n; i++) rdb();
   endtask

   function automatic logic [7:0] rnd_arg();
      case ($urandom % 8)
         0: return 8'hAA;
         1: return 8'h00;
         2: return {4'($urandom_range(2, 9)), 4'($urandom_range(2, 13))};
         3: return {6'($urandom), 2'($urandom)};
         default: return 8'($urandom);
      endcase
   endfunction

   function automatic logic [7:0] rnd_cmd();
      int r;
      r = $urandom % 24;
      if (r < 24 - 3) return 8'h80 + 8'(r);
      if (r == 21) return 8'hFF;
      if (r == 22) return 8'h7F;
      return 8'hA5;
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_reset_settings();
      m_err = 0; m_pull = 0; m_dir = 0; m_state = 0; m_cmd = 8'hFF; m_cnt = 0; gpio_tgt = 0;
      repeat (3) @(negedge clk);
      // R1 reset values, literal
      chk("R1 cfg", {8'h0, cfg_o}, 16'h80);
      chk("R1 active", {8'h0, active_o}, 16'd125);
      chk("R1 debounce", {8'h0, debounce_o}, 16'd3);
      chk("R1 size", {8'h0, size_o}, 16'h33);
      chk("R1 clock", {8'h0, clock_o}, 16'h08);
      chk("R1 status", {8'h0, status_o}, 16'h10);
      chk("R1 irq", {15'h0, irq_n_o}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all();

      // directed corners
      rtx(8'h80, 3);                     // R10 id bytes
      rtx(8'h82, 2);                     // R12 status held while not initialised
      wtx(8'h81, 1, 8'h05);              // R12 config clears status
      rtx(8'h92, 2);
      wtx(8'h85, 2, 8'h34, 8'h12);       // R4
      rtx(8'h87, 3);
      wtx(8'h86, 3, 8'h01, 8'h02, 8'h03);// R8 surplus arg
      wtx(8'h90, 1, 8'h3C);              // R5 edges
      wtx(8'h90, 1, 8'h3D);
      wtx(8'h90, 1, 8'h93);
      wtx(8'h90, 1, 8'h23);
      wtx(8'h93, 1, 8'h03);              // R7
      wtx(8'h93, 1, 8'h01);
      rtx(8'h94, 1);
      wtx(8'h8F, 1, 8'h00);              // R6
      rtx(8'h82, 1);
      wtx(8'h83, 1, 8'h55);              // R3
      wtx(8'h83, 1, 8'hAA);
      rtx(8'h7F, 1);                     // R9
      wtx(8'h80, 1, 8'h00);
      ext_rd_data_i = 8'hC3;
      rtx(8'h89, 2);                     // R13
      wtx(8'h95, 3, 8'h05, 8'h11, 8'h22);
      rtx(8'h8C, 1);

      // constrained random
      for (int t = 0; t < 700; t++) begin
         ext_rd_data_i = 8'($urandom);
         if ($urandom % 5 < 3) begin
            int n;
            n = $urandom % 4;
            wtx(rnd_cmd(), n, rnd_arg(), rnd_arg(), rnd_arg());
         end else begin
            rtx(rnd_cmd(), 1 + ($urandom % 3));
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule